// File: doc/BRIEF.md
# Loadable Binary Counter with Synchronous Clear

This block is a parameterized binary up-counter assembled from a chain of identical bit slices. Each slice owns two small functions. One produces that bit's next count value. The other produces a fast carry that ripples to the next slice. A two-way selector picks either the incremented value or parallel load data. That choice is then gated by an active-low clear before it reaches the register.

The block has no direction control, and the clear input takes the position a cascade input would otherwise use. The count enable starts the carry chain. The carry out of the last slice can drive the enable of a following counter stage, so wider counters can be built by chaining stages. All changes happen on the rising clock edge. Priority, from highest to lowest, is clear, load, count, hold.

Top module: `lcnt_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes all zeros after that edge, whatever `ld`, `ld_val` and `cnt_en` are.
- R2: When `clr_n` is 1 and `ld` is 1 at a rising edge, `q` takes the value of `ld_val` after that edge, whatever `cnt_en` is.
- R3: When `clr_n` is 1, `ld` is 0 and `cnt_en` is 1 at a rising edge, `q` becomes its previous value plus one.
- R4: When `clr_n` is 1, `ld` is 0 and `cnt_en` is 0 at a rising edge, `q` keeps its value.
- R5: Counting up from the all-ones value wraps `q` to all zeros.
- R6: `co` is 1 exactly when `cnt_en` is 1 and every bit of `q` is 1. It follows those inputs combinationally, in the same cycle.
- R7: `q` changes only at a rising clock edge. Input changes between edges leave `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| cnt_en | input | 1 | Count enable; also the carry into bit 0 |
| ld | input | 1 | Synchronous parallel load request |
| ld_val | input | WIDTH | Parallel load data |
| clr_n | input | 1 | Active-low synchronous clear; overrides load and count |
| q | output | WIDTH | Current count value |
| co | output | 1 | Carry out for cascading, high when enabled at all ones |

## Verification
The count value `q` is one register deep. Any clear, load, count or hold request is therefore visible on `q` one rising edge after the inputs are applied. The carry out `co` is purely combinational, so it is due in the same cycle in which `cnt_en` or `q` changes. The bench drives inputs one time unit after each rising edge and checks `q` at that same point after the following edge. It checks `co` after inputs settle and before the next edge. For the edge-only requirement, it also changes inputs in the middle of a cycle and samples `q` again before any edge arrives.

// File: rtl/lcnt_chain.sv
module lcnt_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             cnt_en,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             clr_n,
  output logic [WIDTH-1:0] q,
  output logic             co
);

  logic [WIDTH:0]   cy;
  logic [WIDTH-1:0] nxt;

  assign cy[0] = cnt_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic sum;
    assign sum       = q[i] ^ cy[i];
    assign cy[i+1]   = cy[i] & q[i];
    assign nxt[i]    = (ld ? ld_val[i] : sum) & clr_n;
  end

  always_ff @(posedge clk) q <= nxt;

  assign co = cy[WIDTH];

  logic live = 1'b0;
  always_ff @(posedge clk) if (!clr_n) live <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!live)
    !clr_n |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!live)
    (clr_n && ld) |=> (q == $past(ld_val)));

  assert_count_R3: assert property (@(posedge clk) disable iff (!live)
    (clr_n && !ld && cnt_en) |=> (q == $past(q) + WIDTH'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!live)
    (clr_n && !ld && !cnt_en) |=> $stable(q));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!live)
    (co && clr_n && !ld) |=> (q == '0));

endmodule

// File: tb/test_lcnt_chain.sv
module test_lcnt_chain;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         cnt_en = 1'b0;
  logic         ld = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic         clr_n = 1'b1;
  logic [W-1:0] q;
  logic         co;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lcnt_chain #(.WIDTH(W)) i_lcnt_chain (
    .clk(clk), .cnt_en(cnt_en), .ld(ld), .ld_val(ld_val),
    .clr_n(clr_n), .q(q), .co(co)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_clear();
    clr_n = 1'b0; ld = 1'b1; cnt_en = 1'b1; ld_val = 8'hAA;
    step();
    chk("R1 clear from power-up", q, 8'h00);
    clr_n = 1'b1; ld = 1'b0; cnt_en = 1'b0;
    #1;
    chk("R6 co low at zero", {7'b0, co}, 8'h00);
  endtask

  task automatic t_load();
    ld = 1'b1; cnt_en = 1'b0; ld_val = 8'h5A;
    step();
    chk("R2 load without enable", q, 8'h5A);
    cnt_en = 1'b1; ld_val = 8'h33;
    step();
    chk("R2 load beats count", q, 8'h33);
    ld = 1'b0;
  endtask

  task automatic t_count();
    logic [W-1:0] exp;
    exp = q;
    ld = 1'b0; cnt_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      exp = exp + 8'd1;
      chk("R3 increment", q, exp);
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] exp;
    exp = q;
    cnt_en = 1'b0; ld = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 hold", q, exp);
    end
  endtask

  task automatic t_wrap();
    ld = 1'b1; ld_val = 8'hFE; cnt_en = 1'b0;
    step();
    ld = 1'b0; cnt_en = 1'b1;
    #1;
    chk("R6 co low at FE", {7'b0, co}, 8'h00);
    step();
    chk("R3 count to FF", q, 8'hFF);
    chk("R6 co high at FF enabled", {7'b0, co}, 8'h01);
    cnt_en = 1'b0;
    #1;
    chk("R6 co low when disabled", {7'b0, co}, 8'h00);
    cnt_en = 1'b1;
    step();
    chk("R5 wrap to zero", q, 8'h00);
    chk("R6 co low after wrap", {7'b0, co}, 8'h00);
  endtask

  task automatic t_clear_override();
    ld = 1'b1; ld_val = 8'hC3; cnt_en = 1'b0;
    step();
    clr_n = 1'b0; ld = 1'b1; ld_val = 8'h7E; cnt_en = 1'b1;
    step();
    chk("R1 clear beats load and count", q, 8'h00);
    clr_n = 1'b1; ld = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic t_edge_only();
    ld = 1'b1; ld_val = 8'h96;
    step();
    ld = 1'b0;
    #1;
    ld = 1'b1; ld_val = 8'h11; cnt_en = 1'b1;
    #1;
    chk("R7 no change mid-cycle on load", q, 8'h96);
    clr_n = 1'b0;
    #1;
    chk("R7 no change mid-cycle on clear", q, 8'h96);
    clr_n = 1'b1; ld = 1'b0; cnt_en = 1'b0;
    step();
    chk("R7 hold at next edge", q, 8'h96);
  endtask

  initial begin
    t_reset_clear();
    t_load();
    t_count();
    t_hold();
    t_wrap();
    t_clear_override();
    t_edge_only();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule